// File: doc/BRIEF.md
# Raster Scan Timing Generator

This block produces the scan timing for an 800 by 600 display refreshed at 60 Hz, driven by a 40 MHz pixel clock. Two counters walk the frame. A column counter steps once per pixel clock over a 1056-clock line. A row counter steps once per line over a 628-line frame. Both counters are exported raw, so a separate video stage can choose which pixel to produce.

From the counter values the block decodes a horizontal sync pulse, a vertical sync pulse and a flag that marks the visible area. After the visible span, each axis has a blanking interval. On the column axis this is 40 clocks of front porch, a 128-clock sync pulse and 88 clocks of back porch. On the row axis it is 1 line of front porch, a 4-line sync pulse and 23 lines of back porch. Both sync pulses are active high.

The three decoded flags pass through a register chain of parameterised depth. This lets them arrive at the display in step with colour data that has been delayed by the video stage and an external converter. The counters themselves are not delayed.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both counters become 0 and `h_sync`, `v_sync` and `video_active` become 0. The flags stay 0 for the first SYNC_DELAY clocks after release, until the first decoded value has crossed the delay chain.
- R2: `h_count` rises by one every clock, from 0 up to H_TOTAL-1 (1055 by default), and then returns to 0.
- R3: `v_count` changes only on the clock where `h_count` wraps. On that clock it rises by one, except that from V_TOTAL-1 (627 by default) it returns to 0.
- R4: The undelayed horizontal sync term is 1 exactly when `h_count` lies in [H_VISIBLE+H_FRONT, H_VISIBLE+H_FRONT+H_SYNC-1], which is 840 to 967 by default, and 0 elsewhere.
- R5: The undelayed vertical sync term is 1 exactly when `v_count` lies in [V_VISIBLE+V_FRONT, V_VISIBLE+V_FRONT+V_SYNC-1], which is 601 to 604 by default, and 0 elsewhere.
- R6: The undelayed visible flag is 1 exactly when `h_count` < H_VISIBLE and `v_count` < V_VISIBLE.
- R7: On each output clock, `h_sync`, `v_sync` and `video_active` equal the terms of R4, R5 and R6 evaluated on the counter values from SYNC_DELAY clocks earlier (default 1), while `h_count` and `v_count` carry no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| h_count | output | $clog2(H_TOTAL) (11) | Column position within the line, undelayed |
| v_count | output | $clog2(V_TOTAL) (10) | Row position within the frame, undelayed |
| h_sync | output | 1 | Horizontal sync, active high, delayed by SYNC_DELAY |
| v_sync | output | 1 | Vertical sync, active high, delayed by SYNC_DELAY |
| video_active | output | 1 | Visible-area flag, delayed by SYNC_DELAY |

## Verification
The column wrap and the row step fall in the same clock. At the end of the last line, both counters must also return to zero together. The bench waits for `h_count` to reach its last value and judges the next clock: the column must be 0 and the row must be one higher. In a reduced-size instance, it also drives the counters to the last pixel of the frame and expects both of them at 0 on the next clock. It also compares every output against an independent reference on every clock, including the clocks where a delayed sync edge lines up with a counter wrap.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Default scan geometry: 800x600 at 60 Hz with a 40 MHz pixel clock
    localparam int unsigned DEF_H_VISIBLE = 800;
    localparam int unsigned DEF_H_FRONT   = 40;
    localparam int unsigned DEF_H_SYNC    = 128;
    localparam int unsigned DEF_H_BACK    = 88;
    localparam int unsigned DEF_V_VISIBLE = 600;
    localparam int unsigned DEF_V_FRONT   = 1;
    localparam int unsigned DEF_V_SYNC    = 4;
    localparam int unsigned DEF_V_BACK    = 23;

    // Decoded per-position flags that travel through the delay chain
    typedef struct packed {
        logic hs;
        logic vs;
        logic act;
    } raster_flags_t;

    localparam raster_flags_t FLAGS_IDLE = '{hs: 1'b0, vs: 1'b0, act: 1'b0};

    // True when pos falls inside [lo, lo+len)
    function automatic logic in_span(input int unsigned pos,
                                     input int unsigned lo,
                                     input int unsigned len);
        return (pos >= lo) && (pos < lo + len);
    endfunction

endpackage

// File: rtl/raster_axis_counter.sv
module raster_axis_counter #(
    parameter int unsigned TOTAL = 1056,
    localparam int unsigned W    = $clog2(TOTAL)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] count,
    output logic         at_last
);
    localparam logic [W-1:0] LAST = W'(TOTAL - 1);

    assign at_last = (count == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (adv) begin
            count <= at_last ? '0 : count + W'(1);
        end
    end
endmodule

// File: rtl/raster_decode.sv
module raster_decode
    import raster_pkg::*;
#(
    parameter int unsigned H_VISIBLE = DEF_H_VISIBLE,
    parameter int unsigned H_FRONT   = DEF_H_FRONT,
    parameter int unsigned H_SYNC    = DEF_H_SYNC,
    parameter int unsigned V_VISIBLE = DEF_V_VISIBLE,
    parameter int unsigned V_FRONT   = DEF_V_FRONT,
    parameter int unsigned V_SYNC    = DEF_V_SYNC,
    parameter int unsigned HW        = 11,
    parameter int unsigned VW        = 10
) (
    input  logic [HW-1:0]  h_pos,
    input  logic [VW-1:0]  v_pos,
    output raster_flags_t  flags
);
    localparam int unsigned H_SYNC_START = H_VISIBLE + H_FRONT;
    localparam int unsigned V_SYNC_START = V_VISIBLE + V_FRONT;

    always_comb begin
        flags.hs  = in_span(32'(h_pos), H_SYNC_START, H_SYNC);
        flags.vs  = in_span(32'(v_pos), V_SYNC_START, V_SYNC);
        flags.act = in_span(32'(h_pos), 0, H_VISIBLE) && in_span(32'(v_pos), 0, V_VISIBLE);
    end
endmodule

// File: rtl/raster_flag_delay.sv
module raster_flag_delay
    import raster_pkg::*;
#(
    parameter int unsigned DEPTH = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  raster_flags_t d_in,
    output raster_flags_t d_out
);
    generate
        if (DEPTH == 0) begin : g_bypass
            assign d_out = d_in;
        end else begin : g_chain
            raster_flags_t stage [DEPTH];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < int'(DEPTH); k++) begin
                        stage[k] <= FLAGS_IDLE;
                    end
                end else begin
                    stage[0] <= d_in;
                    for (int k = 1; k < int'(DEPTH); k++) begin
                        stage[k] <= stage[k-1];
                    end
                end
            end

            assign d_out = stage[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int unsigned H_VISIBLE  = DEF_H_VISIBLE,
    parameter int unsigned H_FRONT    = DEF_H_FRONT,
    parameter int unsigned H_SYNC     = DEF_H_SYNC,
    parameter int unsigned H_BACK     = DEF_H_BACK,
    parameter int unsigned V_VISIBLE  = DEF_V_VISIBLE,
    parameter int unsigned V_FRONT    = DEF_V_FRONT,
    parameter int unsigned V_SYNC     = DEF_V_SYNC,
    parameter int unsigned V_BACK     = DEF_V_BACK,
    parameter int unsigned SYNC_DELAY = 1,
    localparam int unsigned H_TOTAL   = H_VISIBLE + H_FRONT + H_SYNC + H_BACK,
    localparam int unsigned V_TOTAL   = V_VISIBLE + V_FRONT + V_SYNC + V_BACK,
    localparam int unsigned HW        = $clog2(H_TOTAL),
    localparam int unsigned VW        = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] h_count,
    output logic [VW-1:0] v_count,
    output logic          h_sync,
    output logic          v_sync,
    output logic          video_active
);
    logic          h_last;
    logic          v_last;
    raster_flags_t raw_flags;
    raster_flags_t late_flags;

    // Column counter steps every clock
    raster_axis_counter #(.TOTAL(H_TOTAL)) u_h_ctr (
        .clk     (clk),
        .rst     (rst),
        .adv     (1'b1),
        .count   (h_count),
        .at_last (h_last)
    );

    // Row counter steps when the column counter wraps
    raster_axis_counter #(.TOTAL(V_TOTAL)) u_v_ctr (
        .clk     (clk),
        .rst     (rst),
        .adv     (h_last),
        .count   (v_count),
        .at_last (v_last)
    );

    raster_decode #(
        .H_VISIBLE (H_VISIBLE),
        .H_FRONT   (H_FRONT),
        .H_SYNC    (H_SYNC),
        .V_VISIBLE (V_VISIBLE),
        .V_FRONT   (V_FRONT),
        .V_SYNC    (V_SYNC),
        .HW        (HW),
        .VW        (VW)
    ) u_decode (
        .h_pos (h_count),
        .v_pos (v_count),
        .flags (raw_flags)
    );

    // Aligns the flags with the colour path latency
    raster_flag_delay #(.DEPTH(SYNC_DELAY)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_flags),
        .d_out (late_flags)
    );

    assign h_sync       = late_flags.hs;
    assign v_sync       = late_flags.vs;
    assign video_active = late_flags.act;

    // v_last only marks the frame end for observers; kept unused here
    logic unused_ok;
    assign unused_ok = v_last;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
    parameter int unsigned H_VISIBLE  = 800,
    parameter int unsigned H_FRONT    = 40,
    parameter int unsigned H_SYNC     = 128,
    parameter int unsigned H_BACK     = 88,
    parameter int unsigned V_VISIBLE  = 600,
    parameter int unsigned V_FRONT    = 1,
    parameter int unsigned V_SYNC     = 4,
    parameter int unsigned V_BACK     = 23,
    parameter int unsigned SYNC_DELAY = 1,
    localparam int unsigned H_TOTAL   = H_VISIBLE + H_FRONT + H_SYNC + H_BACK,
    localparam int unsigned V_TOTAL   = V_VISIBLE + V_FRONT + V_SYNC + V_BACK,
    localparam int unsigned HW        = $clog2(H_TOTAL),
    localparam int unsigned VW        = $clog2(V_TOTAL)
) (
    input logic          clk,
    input logic          rst,
    input logic [HW-1:0] h_count,
    input logic [VW-1:0] v_count,
    input logic          h_sync,
    input logic          v_sync,
    input logic          video_active
);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (h_count == '0 && v_count == '0 && !h_sync && !v_sync && !video_active));

    // R2
    h_step_chk: assert property (@(posedge clk) disable iff (rst)
        (h_count != H_LAST) |=> (h_count == $past(h_count) + HW'(1)));

    // R2
    h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (h_count == H_LAST) |=> (h_count == '0));

    // R3
    v_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (h_count != H_LAST) |=> $stable(v_count));

    // R3
    v_step_chk: assert property (@(posedge clk) disable iff (rst)
        (h_count == H_LAST && v_count != V_LAST) |=> (v_count == $past(v_count) + VW'(1)));

    // R3
    v_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (h_count == H_LAST && v_count == V_LAST) |=> (v_count == '0));

    // R4
    hs_blank_chk: assert property (@(posedge clk) disable iff (rst)
        h_sync |-> !video_active);

    // R5
    vs_blank_chk: assert property (@(posedge clk) disable iff (rst)
        v_sync |-> !video_active);

    generate
        if (SYNC_DELAY > 0) begin : g_align
            logic [2:0] want_now;
            logic [2:0] want_q [SYNC_DELAY];

            always_comb begin
                want_now[2] = (32'(h_count) >= H_VISIBLE + H_FRONT) &&
                              (32'(h_count) <  H_VISIBLE + H_FRONT + H_SYNC);
                want_now[1] = (32'(v_count) >= V_VISIBLE + V_FRONT) &&
                              (32'(v_count) <  V_VISIBLE + V_FRONT + V_SYNC);
                want_now[0] = (32'(h_count) < H_VISIBLE) && (32'(v_count) < V_VISIBLE);
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < int'(SYNC_DELAY); k++) want_q[k] <= '0;
                end else begin
                    want_q[0] <= want_now;
                    for (int k = 1; k < int'(SYNC_DELAY); k++) want_q[k] <= want_q[k-1];
                end
            end

            // R7
            flag_align_chk: assert property (@(posedge clk) disable iff (rst)
                {h_sync, v_sync, video_active} == want_q[SYNC_DELAY-1]);
        end
    endgenerate
endmodule

bind raster_timing_gen raster_timing_chk #(
    .H_VISIBLE  (H_VISIBLE),
    .H_FRONT    (H_FRONT),
    .H_SYNC     (H_SYNC),
    .H_BACK     (H_BACK),
    .V_VISIBLE  (V_VISIBLE),
    .V_FRONT    (V_FRONT),
    .V_SYNC     (V_SYNC),
    .V_BACK     (V_BACK),
    .SYNC_DELAY (SYNC_DELAY)
) u_timing_chk (
    .clk          (clk),
    .rst          (rst),
    .h_count      (h_count),
    .v_count      (v_count),
    .h_sync       (h_sync),
    .v_sync       (v_sync),
    .video_active (video_active)
);

// File: tb/raster_ref.sv
module raster_ref #(
    parameter int HV = 800, parameter int HF = 40, parameter int HS = 128, parameter int HB = 88,
    parameter int VV = 600, parameter int VF = 1,  parameter int VS = 4,   parameter int VB = 23,
    parameter int DLY = 1
) (
    input  logic clk,
    input  logic rst,
    output int   eh,
    output int   ev,
    output logic ehs,
    output logic evs,
    output logic eact
);
    localparam int HT = HV + HF + HS + HB;
    localparam int VT = VV + VF + VS + VB;

    logic [2:0] pipe [DLY];
    logic [2:0] now_f;

    always_comb begin
        now_f[2] = (eh >= HV + HF) && (eh < HV + HF + HS);
        now_f[1] = (ev >= VV + VF) && (ev < VV + VF + VS);
        now_f[0] = (eh < HV) && (ev < VV);
    end

    always @(posedge clk) begin
        if (rst) begin
            eh <= 0;
            ev <= 0;
            for (int k = 0; k < DLY; k++) pipe[k] <= 3'b000;
        end else begin
            pipe[0] <= now_f;
            for (int k = 1; k < DLY; k++) pipe[k] <= pipe[k-1];
            if (eh == HT - 1) begin
                eh <= 0;
                ev <= (ev == VT - 1) ? 0 : ev + 1;
            end else begin
                eh <= eh + 1;
            end
        end
    end

    assign ehs  = pipe[DLY-1][2];
    assign evs  = pipe[DLY-1][1];
    assign eact = pipe[DLY-1][0];
endmodule

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    // Full-size instance, default parameters
    logic [10:0] h_d;
    logic [9:0]  v_d;
    logic        hs_d, vs_d, act_d;

    raster_timing_gen dut_i (
        .clk(clk), .rst(rst), .h_count(h_d), .v_count(v_d),
        .h_sync(hs_d), .v_sync(vs_d), .video_active(act_d)
    );

    // Reduced instance: 8+2+3+2 = 15 columns, 6+1+2+3 = 12 rows, delay 3
    logic [3:0] h_s;
    logic [3:0] v_s;
    logic       hs_s, vs_s, act_s;

    raster_timing_gen #(
        .H_VISIBLE(8), .H_FRONT(2), .H_SYNC(3), .H_BACK(2),
        .V_VISIBLE(6), .V_FRONT(1), .V_SYNC(2), .V_BACK(3),
        .SYNC_DELAY(3)
    ) dut_small_i (
        .clk(clk), .rst(rst), .h_count(h_s), .v_count(v_s),
        .h_sync(hs_s), .v_sync(vs_s), .video_active(act_s)
    );

    int   rh_d, rv_d, rh_s, rv_s;
    logic rhs_d, rvs_d, ract_d, rhs_s, rvs_s, ract_s;

    raster_ref ref_d (
        .clk(clk), .rst(rst), .eh(rh_d), .ev(rv_d), .ehs(rhs_d), .evs(rvs_d), .eact(ract_d)
    );

    raster_ref #(.HV(8), .HF(2), .HS(3), .HB(2), .VV(6), .VF(1), .VS(2), .VB(3), .DLY(3)) ref_s (
        .clk(clk), .rst(rst), .eh(rh_s), .ev(rv_s), .ehs(rhs_s), .evs(rvs_s), .eact(ract_s)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(int'(h_d) == rh_d, "R2 full h_count", int'(h_d), rh_d);
        check(int'(v_d) == rv_d, "R3 full v_count", int'(v_d), rv_d);
        check(hs_d == rhs_d, "R4/R7 full h_sync", hs_d, rhs_d);
        check(vs_d == rvs_d, "R5/R7 full v_sync", vs_d, rvs_d);
        check(act_d == ract_d, "R6/R7 full video_active", act_d, ract_d);
        check(int'(h_s) == rh_s, "R2 small h_count", int'(h_s), rh_s);
        check(int'(v_s) == rv_s, "R3 small v_count", int'(v_s), rv_s);
        check(hs_s == rhs_s, "R4/R7 small h_sync", hs_s, rhs_s);
        check(vs_s == rvs_s, "R5/R7 small v_sync", vs_s, rvs_s);
        check(act_s == ract_s, "R6/R7 small video_active", act_s, ract_s);
    endtask

    // R1: outputs cleared under reset
    task automatic t_reset_state();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        check(h_d == '0 && v_d == '0, "R1 counters in reset", int'(h_d) + int'(v_d), 0);
        check({hs_d, vs_d, act_d} == 3'b000, "R1 flags in reset", {hs_d, vs_d, act_d}, 0);
        check(h_s == '0 && v_s == '0 && {hs_s, vs_s, act_s} == 3'b000, "R1 small in reset",
              {h_s, v_s, hs_s, vs_s, act_s}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(h_d == 11'd1, "R2 first step after release", int'(h_d), 1);
        check(act_d == 1'b1, "R7 full flag after one stage", act_d, 1);
        check(act_s == 1'b0, "R1 small flag still held", act_s, 0);
    endtask

    task automatic t_compare(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    // R2, R3: column wrap and row step in the same clock
    task automatic t_line_wrap();
        int row;
        while (h_d != 11'd1055) @(negedge clk);
        row = int'(v_d);
        @(negedge clk);
        check(h_d == '0, "R2 column wrap", int'(h_d), 0);
        check(int'(v_d) == row + 1, "R3 row step on wrap", int'(v_d), row + 1);
    endtask

    // R4, R6: window edges on the full instance with one-clock delay
    task automatic t_full_windows();
        while (h_d != 11'd800) @(negedge clk);
        check(act_d == 1'b1, "R6 last visible column seen at 800", act_d, 1);
        @(negedge clk);
        check(act_d == 1'b0, "R6 blank after column 799", act_d, 0);
        while (h_d != 11'd840) @(negedge clk);
        check(hs_d == 1'b0, "R4 sync not yet at 839", hs_d, 0);
        @(negedge clk);
        check(hs_d == 1'b1, "R4 sync from column 840", hs_d, 1);
        while (h_d != 11'd968) @(negedge clk);
        check(hs_d == 1'b1, "R4 sync at column 967", hs_d, 1);
        @(negedge clk);
        check(hs_d == 1'b0, "R4 sync ends after 967", hs_d, 0);
        while (h_d != 11'd0) @(negedge clk);
        check(act_d == 1'b0, "R6 blank from column 1055", act_d, 0);
        @(negedge clk);
        check(act_d == 1'b1, "R6 visible again from column 0", act_d, 1);
    endtask

    // R7: three-stage delay on the small instance
    task automatic t_small_delay();
        while (h_s != 4'd12) @(negedge clk);
        check(hs_s == 1'b0, "R7 small sync not out two clocks after 10", hs_s, 0);
        @(negedge clk);
        check(hs_s == 1'b1, "R7 small sync three clocks after column 10", hs_s, 1);
    endtask

    // R5, R3: vertical sync and frame wrap on the small instance
    task automatic t_small_frame();
        while (!(v_s == 4'd7 && h_s == 4'd2)) @(negedge clk);
        check(vs_s == 1'b0, "R5 small vsync not before row 7", vs_s, 0);
        @(negedge clk);
        check(vs_s == 1'b1, "R5 small vsync for row 7", vs_s, 1);
        while (!(v_s == 4'd11 && h_s == 4'd14)) @(negedge clk);
        @(negedge clk);
        check(h_s == '0 && v_s == '0, "R3 small frame wrap", {v_s, h_s}, 0);
    endtask

    // R1: reset in the middle of a frame
    task automatic t_mid_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        check(h_d == '0 && v_d == '0 && h_s == '0 && v_s == '0, "R1 mid-frame counters",
              int'(h_d) + int'(v_d) + int'(h_s) + int'(v_s), 0);
        check({hs_d, vs_d, act_d, hs_s, vs_s, act_s} == 6'b0, "R1 mid-frame flags",
              {hs_d, vs_d, act_d, hs_s, vs_s, act_s}, 0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_compare(2500);
        t_line_wrap();
        t_full_windows();
        t_small_delay();
        t_small_frame();
        t_line_wrap();
        t_compare(400);
        t_mid_reset();
        t_compare(3000);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule